// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block follows the reservation that one core holds between a load-linked access and the store-conditional that ends it. A load-exclusive records which aligned granule of memory the core wants to update atomically, and the monitor moves to the exclusive state. The reservation is lost through any of these events: an ordinary store by the same core into that granule, a snooped store or invalidation from another core into it, or an exception. When the store-exclusive arrives, the monitor decides whether the store may go ahead. It gates the memory write in the same cycle and reports a pass/fail status on the next cycle. The monitor always returns to the open state afterwards.

The granule is the set of addresses that share bits [31:GRAN_LSB], so one tag covers 2^(GRAN_LSB-2) words. Two cores that run the same retry loop can keep stealing the line from each other and never finish. To stop this, the monitor opens a hold-off window of HOLD_CYC cycles after each load-exclusive. A remote invalidation of the reserved granule that arrives inside the window is recorded and takes effect later. If the store-exclusive comes first, the core completes its sequence.

Top module: `excl_monitor`

## Requirements
- R1: The reservation tag is load address bits [31:GRAN_LSB]. With GRAN_LSB = 4, a load-exclusive of 0x000341B4 gives `resv_tag` 0x000341B, and every address from 0x000341B0 to 0x000341BF lies inside the granule.
- R2: After reset the monitor is open (`excl_state` = 0), and `stx_fail` and `stx_done` are 0.
- R3: A load-exclusive with no store-exclusive in the same cycle makes the monitor exclusive and loads the tag on the next edge. A load-exclusive that arrives in the same cycle as a store-exclusive is ignored.
- R4: Every store-exclusive leaves the monitor open after its edge, whether it passes or fails.
- R5: `stx_wr_en` is high in the store-exclusive cycle only when the monitor is exclusive, the store address is inside the tagged granule, and no clearing event happens in that cycle. A store-exclusive to another granule never raises `stx_wr_en`.
- R6: One cycle after a store-exclusive, `stx_done` pulses high and `stx_fail` reads 0 for success and 1 for failure.
- R7: Outside the hold-off window, a remote store into the tagged granule clears the reservation at the next edge. A remote store into another granule has no effect.
- R8: A local ordinary store inside the tagged granule clears the reservation. A local store outside it leaves the monitor unchanged.
- R9: An exception pulse (`trap`) clears the reservation.
- R10: For HOLD_CYC cycles after a load-exclusive, a remote store into the tagged granule is only recorded. A store-exclusive in that window still succeeds.
- R11: A recorded remote store takes effect in the first cycle after the window ends. The monitor is open after that edge, and a store-exclusive in that cycle fails.
- R12: A store-exclusive in the same cycle as a trap or a clearing local store fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_valid | input | 1 | Load-exclusive request |
| ldx_addr | input | 32 | Load-exclusive byte address |
| stx_valid | input | 1 | Store-exclusive request |
| stx_addr | input | 32 | Store-exclusive byte address |
| lst_valid | input | 1 | Local ordinary store |
| lst_addr | input | 32 | Local ordinary store address |
| rinv_valid | input | 1 | Snooped remote store or invalidation |
| rinv_addr | input | 32 | Snooped address |
| trap | input | 1 | Exception or trap pulse |
| stx_wr_en | output | 1 | Write gate for the conditional store, same cycle |
| stx_fail | output | 1 | Status, 0 success / 1 fail, one cycle after request |
| stx_done | output | 1 | Status valid pulse |
| excl_state | output | 1 | 1 when a reservation is held |
| resv_tag | output | 32-GRAN_LSB | Tagged granule |

## Verification
The write gate `stx_wr_en` is combinational, so the bench reads it inside the request cycle, just before the edge. `stx_fail`, `stx_done`, `excl_state` and `resv_tag` all change on the edge that takes the request, so the bench samples them one time unit after that edge. For the hold-off cases the bench counts edges from the load-exclusive: the window lasts HOLD_CYC cycles, and a recorded invalidation makes the monitor open one edge after the window closes. The bench expects the state to change exactly on that edge and not before.

// File: rtl/emon_pkg.sv
package emon_pkg;
  localparam int AW = 32;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;

  // Address sources checked against the held tag
  localparam int SRC_STX  = 0;
  localparam int SRC_LST  = 1;
  localparam int SRC_RINV = 2;
  localparam int NSRC     = 3;

  // Granule index of a byte address: bits above the granule offset
  function automatic logic [AW-1:0] granule_of(input logic [AW-1:0] a,
                                               input int unsigned lsb);
    return a >> lsb;
  endfunction
endpackage

// File: rtl/emon_granule_cmp.sv
module emon_granule_cmp #(
  parameter int GRAN_LSB = 4,
  localparam int TAG_W = emon_pkg::AW - GRAN_LSB
) (
  input  logic                   valid,
  input  logic                   armed,
  input  logic [emon_pkg::AW-1:0] addr,
  input  logic [TAG_W-1:0]       tag,
  output logic                   hit
);
  logic [emon_pkg::AW-1:0] gidx;

  assign gidx = emon_pkg::granule_of(addr, GRAN_LSB);
  assign hit  = valid && armed && (gidx == {{GRAN_LSB{1'b0}}, tag});
endmodule

// File: rtl/emon_holdoff.sv
module emon_holdoff #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic drop,
  input  logic rinv_hit,
  output logic win_active,
  output logic pend_q,
  output logic pend_fire
);
  generate
    if (HOLD_CYC == 0) begin : g_nohold
      assign win_active = 1'b0;
      assign pend_q     = 1'b0;
      assign pend_fire  = 1'b0;
    end else begin : g_hold
      localparam int CW = $clog2(HOLD_CYC + 1);
      logic [CW-1:0] cnt_q;
      logic          pend_r;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (arm) begin
          cnt_q <= CW'(HOLD_CYC);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_r <= 1'b0;
        end else if (arm || drop) begin
          pend_r <= 1'b0;
        end else if (rinv_hit && win_active) begin
          pend_r <= 1'b1;
        end
      end

      assign win_active = (cnt_q != '0);
      assign pend_q     = pend_r;
      assign pend_fire  = pend_r && !win_active;
    end
  endgenerate
endmodule

// File: rtl/emon_core.sv
module emon_core #(
  parameter int GRAN_LSB = 4,
  localparam int TAG_W = emon_pkg::AW - GRAN_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ldx_valid,
  input  logic [TAG_W-1:0] ldx_tag,
  input  logic             stx_valid,
  input  logic             stx_hit,
  input  logic             clear_evt,
  output emon_pkg::mon_state_e state_q,
  output logic [TAG_W-1:0] tag_q,
  output logic             wr_en,
  output logic             fail_q,
  output logic             done_q
);
  import emon_pkg::*;

  mon_state_e state_d;

  assign wr_en = stx_valid && stx_hit && !clear_evt;

  always_comb begin
    state_d = state_q;
    if (stx_valid)      state_d = MON_OPEN;
    else if (ldx_valid) state_d = MON_EXCL;
    else if (clear_evt) state_d = MON_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MON_OPEN;
      tag_q   <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ldx_valid && !stx_valid) tag_q <= ldx_tag;
      fail_q <= stx_valid && !wr_en;
      done_q <= stx_valid;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int GRAN_LSB = 4,
  parameter int HOLD_CYC = 3,
  localparam int TAG_W = 32 - GRAN_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ldx_valid,
  input  logic [31:0]      ldx_addr,
  input  logic             stx_valid,
  input  logic [31:0]      stx_addr,
  input  logic             lst_valid,
  input  logic [31:0]      lst_addr,
  input  logic             rinv_valid,
  input  logic [31:0]      rinv_addr,
  input  logic             trap,
  output logic             stx_wr_en,
  output logic             stx_fail,
  output logic             stx_done,
  output logic             excl_state,
  output logic [TAG_W-1:0] resv_tag
);
  import emon_pkg::*;

  mon_state_e       state_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] ldx_tag;
  logic             armed;
  logic [31:0]      src_addr [NSRC];
  logic             src_vld  [NSRC];
  logic             src_hit  [NSRC];
  logic             win_active;
  logic             pend_q;
  logic             pend_fire;
  logic             rinv_now;
  logic             clear_evt;
  logic             arm;
  logic             drop;

  assign armed   = (state_q == MON_EXCL);
  assign ldx_tag = TAG_W'(granule_of(ldx_addr, GRAN_LSB));

  assign src_addr[SRC_STX]  = stx_addr;
  assign src_vld[SRC_STX]   = stx_valid;
  assign src_addr[SRC_LST]  = lst_addr;
  assign src_vld[SRC_LST]   = lst_valid;
  assign src_addr[SRC_RINV] = rinv_addr;
  assign src_vld[SRC_RINV]  = rinv_valid;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
      emon_granule_cmp #(.GRAN_LSB(GRAN_LSB)) u_cmp (
        .valid (src_vld[i]),
        .armed (armed),
        .addr  (src_addr[i]),
        .tag   (tag_q),
        .hit   (src_hit[i])
      );
    end
  endgenerate

  // Remote hit acts at once only outside the hold-off window
  assign rinv_now  = src_hit[SRC_RINV] && !win_active;
  assign clear_evt = trap || src_hit[SRC_LST] || rinv_now || pend_fire;
  assign arm       = ldx_valid && !stx_valid;
  assign drop      = armed && (stx_valid || (!ldx_valid && clear_evt));

  emon_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .drop       (drop),
    .rinv_hit   (src_hit[SRC_RINV]),
    .win_active (win_active),
    .pend_q     (pend_q),
    .pend_fire  (pend_fire)
  );

  emon_core #(.GRAN_LSB(GRAN_LSB)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ldx_valid (ldx_valid),
    .ldx_tag   (ldx_tag),
    .stx_valid (stx_valid),
    .stx_hit   (src_hit[SRC_STX]),
    .clear_evt (clear_evt),
    .state_q   (state_q),
    .tag_q     (tag_q),
    .wr_en     (stx_wr_en),
    .fail_q    (stx_fail),
    .done_q    (stx_done)
  );

  assign excl_state = armed;
  assign resv_tag   = tag_q;
endmodule

// File: rtl/emon_checker.sv
module emon_checker (
  input logic clk,
  input logic rst_n,
  input logic ldx_valid,
  input logic stx_valid,
  input logic trap,
  input logic stx_wr_en,
  input logic stx_fail,
  input logic stx_done,
  input logic excl_state,
  input logic win_active,
  input logic pend_q,
  input logic clear_evt
);
  p_ldx_enters_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ldx_valid && !stx_valid) |=> excl_state);

  p_stx_to_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stx_valid |=> !excl_state);

  p_wr_needs_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stx_wr_en |-> (excl_state && stx_valid));

  p_status_matches_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stx_valid |=> (stx_done && (stx_fail == !$past(stx_wr_en))));

  p_trap_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && !ldx_valid) |=> !excl_state);

  p_pend_needs_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> excl_state);

  p_pend_fire_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !win_active && !ldx_valid) |=> !excl_state);

  p_clear_blocks_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |-> !stx_wr_en);

  p_open_stays_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!excl_state && !ldx_valid) |=> !excl_state);
endmodule

bind excl_monitor emon_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ldx_valid  (ldx_valid),
  .stx_valid  (stx_valid),
  .trap       (trap),
  .stx_wr_en  (stx_wr_en),
  .stx_fail   (stx_fail),
  .stx_done   (stx_done),
  .excl_state (excl_state),
  .win_active (win_active),
  .pend_q     (pend_q),
  .clear_evt  (clear_evt)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
  localparam int GL = 4;
  localparam int HC = 3;
  localparam int TW = 32 - GL;

  logic clk = 1'b0;
  logic rst_n;
  logic ldx_valid, stx_valid, lst_valid, rinv_valid, trap;
  logic [31:0] ldx_addr, stx_addr, lst_addr, rinv_addr;
  logic stx_wr_en, stx_fail, stx_done, excl_state;
  logic [TW-1:0] resv_tag;

  int n_run = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  excl_monitor #(.GRAN_LSB(GL), .HOLD_CYC(HC)) dut (
    .clk(clk), .rst_n(rst_n),
    .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
    .stx_valid(stx_valid), .stx_addr(stx_addr),
    .lst_valid(lst_valid), .lst_addr(lst_addr),
    .rinv_valid(rinv_valid), .rinv_addr(rinv_addr),
    .trap(trap),
    .stx_wr_en(stx_wr_en), .stx_fail(stx_fail), .stx_done(stx_done),
    .excl_state(excl_state), .resv_tag(resv_tag)
  );

  function automatic logic [31:0] gidx(input logic [31:0] a);
    return a / (32'd1 << GL);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    ldx_valid = 0; stx_valid = 0; lst_valid = 0; rinv_valid = 0; trap = 0;
  endtask

  task automatic do_ldx(input logic [31:0] a);
    ldx_valid = 1; ldx_addr = a;
    tick();
    ldx_valid = 0;
  endtask

  // Store-exclusive: gate read inside the cycle, status one edge later
  task automatic do_stx(input logic [31:0] a, input bit exp_ok, input string req);
    stx_valid = 1; stx_addr = a;
    #1;
    chk(stx_wr_en == exp_ok, req, stx_wr_en, exp_ok);
    tick();
    quiet();
    chk(stx_done == 1'b1 && stx_fail == !exp_ok, req, {stx_done, stx_fail}, {1'b1, !exp_ok});
    chk(excl_state == 1'b0, "R4", excl_state, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_run++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    quiet();
    ldx_addr = 0; stx_addr = 0; lst_addr = 0; rinv_addr = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    tick();
    // R2 reset state
    chk(excl_state == 0 && stx_fail == 0 && stx_done == 0, "R2",
        {excl_state, stx_fail, stx_done}, 0);

    // R1 tag extraction over several addresses
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      a = 32'h000341B4 + 32'(i) * 32'h01357913;
      do_ldx(a);
      chk(excl_state == 1, "R3", excl_state, 1);
      chk(resv_tag == TW'(gidx(a)), "R1", resv_tag, gidx(a));
    end
    do_stx(32'h0, 1'b0, "R5");

    // R1/R5 granule sweep around the example address
    for (int k = 0; k < 16; k++) begin
      logic [31:0] s;
      s = 32'h000341A0 + 32'(k) * 4;
      do_ldx(32'h000341B4);
      chk(resv_tag == 28'h000341B, "R1", resv_tag, 28'h000341B);
      do_stx(s, gidx(s) == gidx(32'h000341B4), "R5");
    end

    // R5 store-exclusive with no reservation
    do_stx(32'h000341B4, 1'b0, "R5");

    // R4 failed store still opens; retry fails
    do_ldx(32'h00001000);
    do_stx(32'h00002000, 1'b0, "R5");
    do_stx(32'h00001000, 1'b0, "R4");

    // R3 load-exclusive with store-exclusive in same cycle is ignored
    ldx_valid = 1; ldx_addr = 32'h00003000;
    do_stx(32'h00003000, 1'b0, "R3");
    chk(excl_state == 0, "R3", excl_state, 0);

    // R7 remote stores outside the window
    do_ldx(32'h00004008);
    idle(HC);
    rinv_valid = 1; rinv_addr = 32'h00004010; tick(); quiet();
    chk(excl_state == 1, "R7", excl_state, 1);
    rinv_valid = 1; rinv_addr = 32'h0000400C; tick(); quiet();
    chk(excl_state == 0, "R7", excl_state, 0);
    do_stx(32'h00004008, 1'b0, "R7");

    // R8 local stores
    do_ldx(32'h00005000);
    lst_valid = 1; lst_addr = 32'h00005020; tick(); quiet();
    chk(excl_state == 1, "R8", excl_state, 1);
    do_stx(32'h00005004, 1'b1, "R8");
    do_ldx(32'h00005000);
    lst_valid = 1; lst_addr = 32'h0000500C; tick(); quiet();
    chk(excl_state == 0, "R8", excl_state, 0);
    do_stx(32'h00005000, 1'b0, "R8");

    // R9 trap clears
    do_ldx(32'h00006000);
    trap = 1; tick(); quiet();
    chk(excl_state == 0, "R9", excl_state, 0);
    do_stx(32'h00006000, 1'b0, "R9");

    // R10 remote hit in window recorded, store-exclusive still wins
    do_ldx(32'h00007000);
    rinv_valid = 1; rinv_addr = 32'h00007004; tick(); quiet();
    chk(excl_state == 1, "R10", excl_state, 1);
    do_stx(32'h00007008, 1'b1, "R10");

    // R11 recorded hit lands the first cycle after the window
    do_ldx(32'h00008000);
    rinv_valid = 1; rinv_addr = 32'h00008000; tick(); quiet();
    idle(HC - 1);
    chk(excl_state == 1, "R11", excl_state, 1);
    tick();
    chk(excl_state == 0, "R11", excl_state, 0);
    do_ldx(32'h00008000);
    rinv_valid = 1; rinv_addr = 32'h00008000; tick(); quiet();
    idle(HC - 1);
    do_stx(32'h00008000, 1'b0, "R11");

    // R12 clearing event in the store-exclusive cycle
    do_ldx(32'h00009000);
    idle(HC + 1);
    trap = 1;
    do_stx(32'h00009000, 1'b0, "R12");
    do_ldx(32'h00009000);
    lst_valid = 1; lst_addr = 32'h00009008;
    do_stx(32'h00009000, 1'b0, "R12");

    // R6 status returns idle the following cycle
    tick();
    chk(stx_done == 0, "R6", stx_done, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule